// File: doc/BRIEF.md
# External Bus Cycle Timing Sequencer

This block times the read and write strobes of an external asynchronous memory bus. A host raises a request together with a direction bit. The sequencer then steps the access through three phases: lead, active and trail. When the trail phase is over it returns a one-cycle acknowledge. Each phase length comes from a configuration field, and reads and writes have separate sets of fields. A doubling bit stretches every phase to twice its length. Only the strobe for the current direction goes low, and only during the active phase.

A ready input from the external device can stretch the active phase. It can be ignored, used as a signal already synchronous to the clock, or passed first through a two-flop synchronizer when the device is asynchronous. Ready is looked at only once the programmed active time has run out. From then on the strobe stays low until ready is seen high.

The sequencer also checks the configuration against the minimum-timing rules of the chosen ready mode and raises a flag when they are broken. The flag only reports the problem: accesses still run with the programmed values. Each access takes a copy of its fields and mode when it is accepted, so changing the configuration during an access does not affect it.

Top module: `ext_bus_seq`

## Requirements
- R1: While reset is asserted, both strobes are high (inactive), the acknowledge is low and the illegal-configuration flag is low.
- R2: The lead phase lasts the lead field of the access direction, in cycles, with both strobes high. It lasts twice that when the doubling bit is 1. A lead field of 0 skips the lead phase.
- R3: The active phase lasts (active field + 1) cycles, or twice that with doubling, before any ready wait. During this phase the strobe of the access direction is low and the other strobe stays high. A direction bit of 0 selects the read strobe and 1 selects the write strobe.
- R4: The trail phase lasts the trail field, in cycles, or twice that with doubling, with both strobes high. A trail of 0 skips it. The acknowledge is high for exactly one cycle, the cycle after the trail phase, and both strobes are high during that cycle.
- R5: A read access uses only the read lead, active and trail fields. A write access uses only the write fields.
- R6: When ready use is off, the ready input has no effect on any phase length.
- R7: In synchronous ready mode (use bit 1, async bit 0), the ready input is sampled directly on each clock edge that would end the active phase. A low sample holds the active phase for another cycle. If ready rises in the cycle that ends at active cycle index D (counting from 0), the strobe stays low for max(active length, D+1) cycles.
- R8: In asynchronous ready mode (use bit 1, async bit 1), ready passes through a two-flop synchronizer before it is used. The same ready timing as in R7 gives a strobe width of max(active length, D+3) cycles.
- R9: The direction, phase lengths and ready mode are captured when the request is accepted. Configuration changes made during the access do not affect it.
- R10: One cycle after any configuration, the illegal flag is 1 exactly when, for the read fields or for the write fields, any of these holds:
  - the lead field is 0;
  - ready use is on and the active field is 0;
  - asynchronous ready mode is selected and lead + active fields < 3.

  The doubling bit has no effect on the flag, and a flagged configuration still runs its accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, held until acknowledge |
| req_we_i | input | 1 | Direction: 1 write, 0 read |
| ack_o | output | 1 | One-cycle end-of-access acknowledge |
| cfg_rd_lead_i | input | LEAD_W | Read lead field |
| cfg_rd_act_i | input | ACT_W | Read active field |
| cfg_rd_trail_i | input | TRAIL_W | Read trail field |
| cfg_wr_lead_i | input | LEAD_W | Write lead field |
| cfg_wr_act_i | input | ACT_W | Write active field |
| cfg_wr_trail_i | input | TRAIL_W | Write trail field |
| cfg_double_i | input | 1 | Doubles every phase |
| cfg_use_ready_i | input | 1 | Enables ready sampling |
| cfg_ready_async_i | input | 1 | Selects synchronized (asynchronous) ready |
| ready_i | input | 1 | External device ready |
| rd_strobe_n_o | output | 1 | Active-low read strobe |
| wr_strobe_n_o | output | 1 | Active-low write strobe |
| cfg_illegal_o | output | 1 | Minimum-timing rule violation flag |

## Verification
The bench builds the sequencer with all three field widths set to 2. At that size every lead, active and trail value, both directions and both doubling settings can be swept one access at a time, and every strobe width is measured against its arithmetic expectation. The same small widths make the illegal-flag table exhaustive: all 256 combinations of read and write lead/active fields under every ready and doubling setting. The ready sweeps release ready at several cycle offsets in both sampling modes, so the one-cycle and three-cycle response latencies are separated from the programmed active length.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_LEAD   = 3'd1,
        PH_ACTIVE = 3'd2,
        PH_TRAIL  = 3'd3,
        PH_ACK    = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        RDY_OFF   = 2'd0,
        RDY_SYNC  = 2'd1,
        RDY_ASYNC = 2'd2
    } rdy_mode_e;

endpackage

// File: rtl/ebs_ready_sync.sv
module ebs_ready_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    generate
        if (STAGES < 2) begin : g_single
            logic flop_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) flop_q <= 1'b0;
                else        flop_q <= d_i;
            end
            assign q_o = flop_q;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d_i};
            end
            assign q_o = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/ebs_phase_len.sv
module ebs_phase_len #(
    parameter int FIELD_W = 4,
    parameter int OUT_W   = 6,
    parameter int ADD_ONE = 0
) (
    input  logic [FIELD_W-1:0] field_i,
    input  logic               dbl_i,
    output logic [OUT_W-1:0]   len_o
);
    logic [OUT_W-1:0] base;

    always_comb begin
        base  = OUT_W'(field_i) + OUT_W'(ADD_ONE);
        len_o = dbl_i ? (base << 1) : base;
    end
endmodule

// File: rtl/ebs_rule_check.sv
module ebs_rule_check
    import ebs_pkg::*;
#(
    parameter int LEAD_W = 4,
    parameter int ACT_W  = 4
) (
    input  logic [LEAD_W-1:0] lead_i,
    input  logic [ACT_W-1:0]  act_i,
    input  rdy_mode_e         mode_i,
    output logic              bad_o
);
    localparam int SUM_W = ((LEAD_W > ACT_W) ? LEAD_W : ACT_W) + 1;

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum   = SUM_W'(lead_i) + SUM_W'(act_i);
        bad_o = (lead_i == '0)
              | ((mode_i != RDY_OFF) && (act_i == '0))
              | ((mode_i == RDY_ASYNC) && (sum < SUM_W'(3)));
    end
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
    import ebs_pkg::*;
#(
    parameter int LEAD_W      = 4,
    parameter int ACT_W       = 4,
    parameter int TRAIL_W     = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic               req_we_i,
    output logic               ack_o,
    input  logic [LEAD_W-1:0]  cfg_rd_lead_i,
    input  logic [ACT_W-1:0]   cfg_rd_act_i,
    input  logic [TRAIL_W-1:0] cfg_rd_trail_i,
    input  logic [LEAD_W-1:0]  cfg_wr_lead_i,
    input  logic [ACT_W-1:0]   cfg_wr_act_i,
    input  logic [TRAIL_W-1:0] cfg_wr_trail_i,
    input  logic               cfg_double_i,
    input  logic               cfg_use_ready_i,
    input  logic               cfg_ready_async_i,
    input  logic               ready_i,
    output logic               rd_strobe_n_o,
    output logic               wr_strobe_n_o,
    output logic               cfg_illegal_o
);
    localparam int ACT_SPAN = ACT_W + 1;
    localparam int MAX_A    = (LEAD_W > ACT_SPAN) ? LEAD_W : ACT_SPAN;
    localparam int MAX_F    = (MAX_A > TRAIL_W) ? MAX_A : TRAIL_W;
    localparam int CNT_W    = MAX_F + 1;

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic             we;
        logic [CNT_W-1:0] act_len;
        logic [CNT_W-1:0] trail_len;
        rdy_mode_e        mode;
        logic             illegal;
    } st_t;

    st_t st_d, st_q;

    // Field selection by requested direction
    logic [LEAD_W-1:0]  lead_sel;
    logic [ACT_W-1:0]   act_sel;
    logic [TRAIL_W-1:0] trail_sel;
    logic [CNT_W-1:0]   lead_len, act_len, trail_len;
    rdy_mode_e          mode_now;

    assign lead_sel  = req_we_i ? cfg_wr_lead_i  : cfg_rd_lead_i;
    assign act_sel   = req_we_i ? cfg_wr_act_i   : cfg_rd_act_i;
    assign trail_sel = req_we_i ? cfg_wr_trail_i : cfg_rd_trail_i;
    assign mode_now  = !cfg_use_ready_i  ? RDY_OFF :
                       cfg_ready_async_i ? RDY_ASYNC : RDY_SYNC;

    ebs_phase_len #(.FIELD_W(LEAD_W), .OUT_W(CNT_W), .ADD_ONE(0)) u_lead_len (
        .field_i(lead_sel), .dbl_i(cfg_double_i), .len_o(lead_len));
    ebs_phase_len #(.FIELD_W(ACT_W), .OUT_W(CNT_W), .ADD_ONE(1)) u_act_len (
        .field_i(act_sel), .dbl_i(cfg_double_i), .len_o(act_len));
    ebs_phase_len #(.FIELD_W(TRAIL_W), .OUT_W(CNT_W), .ADD_ONE(0)) u_trail_len (
        .field_i(trail_sel), .dbl_i(cfg_double_i), .len_o(trail_len));

    // Legality check, one instance per direction
    logic [LEAD_W-1:0] chk_lead [2];
    logic [ACT_W-1:0]  chk_act  [2];
    logic [1:0]        dir_bad;

    assign chk_lead[0] = cfg_rd_lead_i;
    assign chk_lead[1] = cfg_wr_lead_i;
    assign chk_act[0]  = cfg_rd_act_i;
    assign chk_act[1]  = cfg_wr_act_i;

    generate
        for (genvar d = 0; d < 2; d++) begin : g_rule
            ebs_rule_check #(.LEAD_W(LEAD_W), .ACT_W(ACT_W)) u_rule (
                .lead_i(chk_lead[d]),
                .act_i (chk_act[d]),
                .mode_i(mode_now),
                .bad_o (dir_bad[d])
            );
        end
    endgenerate

    // Ready path
    logic rdy_synced;
    logic rdy_seen;

    ebs_ready_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
        .clk(clk), .rst_n(rst_n), .d_i(ready_i), .q_o(rdy_synced));

    assign rdy_seen = (st_q.mode == RDY_ASYNC) ? rdy_synced : ready_i;

    always_comb begin
        st_d         = st_q;
        st_d.illegal = |dir_bad;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (req_i) begin
                    st_d.we        = req_we_i;
                    st_d.act_len   = act_len;
                    st_d.trail_len = trail_len;
                    st_d.mode      = mode_now;
                    if (lead_len != '0) begin
                        st_d.phase = PH_LEAD;
                        st_d.cnt   = lead_len - CNT_W'(1);
                    end else begin
                        st_d.phase = PH_ACTIVE;
                        st_d.cnt   = act_len - CNT_W'(1);
                    end
                end
            end
            PH_LEAD: begin
                if (st_q.cnt == '0) begin
                    st_d.phase = PH_ACTIVE;
                    st_d.cnt   = st_q.act_len - CNT_W'(1);
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
            PH_ACTIVE: begin
                if (st_q.cnt != '0) begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end else if ((st_q.mode == RDY_OFF) || rdy_seen) begin
                    if (st_q.trail_len != '0) begin
                        st_d.phase = PH_TRAIL;
                        st_d.cnt   = st_q.trail_len - CNT_W'(1);
                    end else begin
                        st_d.phase = PH_ACK;
                    end
                end
            end
            PH_TRAIL: begin
                if (st_q.cnt == '0) st_d.phase = PH_ACK;
                else                st_d.cnt   = st_q.cnt - CNT_W'(1);
            end
            PH_ACK:  st_d.phase = PH_IDLE;
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ack_o         = (st_q.phase == PH_ACK);
    assign rd_strobe_n_o = !((st_q.phase == PH_ACTIVE) && !st_q.we);
    assign wr_strobe_n_o = !((st_q.phase == PH_ACTIVE) &&  st_q.we);
    assign cfg_illegal_o = st_q.illegal;

endmodule

// File: rtl/ebs_checker.sv
module ebs_checker #(
    parameter int LEAD_W = 4,
    parameter int ACT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack_o,
    input logic              rd_strobe_n_o,
    input logic              wr_strobe_n_o,
    input logic              cfg_illegal_o,
    input logic [LEAD_W-1:0] cfg_rd_lead_i,
    input logic [ACT_W-1:0]  cfg_rd_act_i,
    input logic [LEAD_W-1:0] cfg_wr_lead_i,
    input logic [ACT_W-1:0]  cfg_wr_act_i,
    input logic              cfg_use_ready_i
);
    // R3: never both strobes active at once
    p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_strobe_n_o && !wr_strobe_n_o));

    // R4: acknowledge is a single-cycle pulse
    p_ack_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    // R4: no strobe active while acknowledging
    p_ack_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (rd_strobe_n_o && wr_strobe_n_o));

    // R10: a zero lead field in either direction is always flagged
    p_zero_lead_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_rd_lead_i == '0) || (cfg_wr_lead_i == '0)) |=> cfg_illegal_o);

    // R10: a zero active field is flagged once ready is used
    p_zero_act_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_use_ready_i && ((cfg_rd_act_i == '0) || (cfg_wr_act_i == '0)))
        |=> cfg_illegal_o);

    // R10: fields of at least 2 satisfy every mode
    p_roomy_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_rd_lead_i >= 2) && (cfg_wr_lead_i >= 2) &&
         (cfg_rd_act_i >= 2) && (cfg_wr_act_i >= 2)) |=> !cfg_illegal_o);
endmodule

bind ext_bus_seq ebs_checker #(.LEAD_W(LEAD_W), .ACT_W(ACT_W)) u_ebs_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .ack_o          (ack_o),
    .rd_strobe_n_o  (rd_strobe_n_o),
    .wr_strobe_n_o  (wr_strobe_n_o),
    .cfg_illegal_o  (cfg_illegal_o),
    .cfg_rd_lead_i  (cfg_rd_lead_i),
    .cfg_rd_act_i   (cfg_rd_act_i),
    .cfg_wr_lead_i  (cfg_wr_lead_i),
    .cfg_wr_act_i   (cfg_wr_act_i),
    .cfg_use_ready_i(cfg_use_ready_i)
);

// File: tb/ext_bus_seq_bench.sv
`timescale 1ns/1ps
module ext_bus_seq_bench;
    localparam int LW = 2;
    localparam int AW = 2;
    localparam int TW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, req_we = 1'b0, ack;
    logic [LW-1:0] rl = 2'd1, wl = 2'd1;
    logic [AW-1:0] ra = 2'd1, wa = 2'd1;
    logic [TW-1:0] rt = 2'd0, wt = 2'd0;
    logic dbl = 1'b0, use_r = 1'b0, async_r = 1'b0, ready = 1'b0;
    logic rd_n, wr_n, illegal;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ext_bus_seq #(.LEAD_W(LW), .ACT_W(AW), .TRAIL_W(TW), .SYNC_STAGES(2)) u_ext_bus_seq (
        .clk(clk), .rst_n(rst_n), .req_i(req), .req_we_i(req_we), .ack_o(ack),
        .cfg_rd_lead_i(rl), .cfg_rd_act_i(ra), .cfg_rd_trail_i(rt),
        .cfg_wr_lead_i(wl), .cfg_wr_act_i(wa), .cfg_wr_trail_i(wt),
        .cfg_double_i(dbl), .cfg_use_ready_i(use_r), .cfg_ready_async_i(async_r),
        .ready_i(ready), .rd_strobe_n_o(rd_n), .wr_strobe_n_o(wr_n),
        .cfg_illegal_o(illegal));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            check(1'b0, "watchdog", cyc, 150000);
            finish_run();
        end
    end

    // One access; measures lead, strobe-low and trail cycles.
    // rdy_d >= 0 raises ready D negedges after the first low-strobe negedge.
    // mutate rewrites the read configuration during the lead phase.
    task automatic run_access(input bit we, input int rdy_d, input bit mutate,
                              output int l, output int w, output int t);
        int guard;
        logic own_n, other_n;
        l = 0; w = 0; t = 0; guard = 0;
        @(negedge clk);
        req = 1'b1; req_we = we;
        forever begin
            @(negedge clk);
            guard++;
            own_n   = we ? wr_n : rd_n;
            other_n = we ? rd_n : wr_n;
            if (!other_n) check(1'b0, "R3 opposite strobe", 0, 1);
            if (ack) begin
                if (!rd_n || !wr_n) check(1'b0, "R4 strobe during ack", 0, 1);
                req = 1'b0;
                break;
            end
            if (!own_n) begin
                w++;
                if (rdy_d >= 0 && w == rdy_d + 1) ready = 1'b1;
            end else if (w == 0) begin
                l++;
                if (mutate && l == 1) begin
                    rl = 2'd0; ra = 2'd3; rt = 2'd3; dbl = 1'b1;
                    use_r = 1'b1; async_r = 1'b1;
                end
            end else begin
                t++;
            end
            if (guard > 200) begin
                check(1'b0, "access hung", guard, 200);
                req = 1'b0;
                break;
            end
        end
    endtask

    function automatic bit exp_bad(input int lead, input int act, input bit u, input bit a);
        return (lead < 1) || (u && act < 1) || (u && a && (lead + act) < 3);
    endfunction

    initial begin
        int l, w, t, m, exp_w;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(rd_n == 1'b1, "R1 rd strobe in reset", int'(rd_n), 1);
        check(wr_n == 1'b1, "R1 wr strobe in reset", int'(wr_n), 1);
        check(ack == 1'b0, "R1 ack in reset", int'(ack), 0);
        check(illegal == 1'b0, "R1 flag in reset", int'(illegal), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 R3 R4 R5: full timing sweep, ready ignored
        for (int we = 0; we < 2; we++)
            for (int ld = 0; ld < 4; ld++)
                for (int ac = 0; ac < 4; ac++)
                    for (int tr = 0; tr < 4; tr++)
                        for (int db = 0; db < 2; db++) begin
                            m = db + 1;
                            dbl = db[0]; use_r = 1'b0; ready = 1'b0;
                            if (we == 1) begin
                                wl = 2'(ld); wa = 2'(ac); wt = 2'(tr);
                                rl = 2'(3 - ld); ra = 2'(3 - ac); rt = 2'(3 - tr);
                            end else begin
                                rl = 2'(ld); ra = 2'(ac); rt = 2'(tr);
                                wl = 2'(3 - ld); wa = 2'(3 - ac); wt = 2'(3 - tr);
                            end
                            run_access(we[0], -1, 1'b0, l, w, t);
                            check(l == ld * m, "R2 R5 lead length", l, ld * m);
                            check(w == (ac + 1) * m, "R3 R5 active length", w, (ac + 1) * m);
                            check(t == tr * m, "R4 R5 trail length", t, tr * m);
                        end

        // R6: ready held low in ignore mode has no effect
        for (int ac = 0; ac < 4; ac++) begin
            rl = 2'd1; ra = 2'(ac); rt = 2'd1; dbl = 1'b0;
            use_r = 1'b0; async_r = 1'b1; ready = 1'b0;
            run_access(1'b0, -1, 1'b0, l, w, t);
            check(w == ac + 1, "R6 ready ignored", w, ac + 1);
        end

        // R7 R8: ready stretching in both sampling modes
        for (int md = 0; md < 2; md++)
            for (int ac = 0; ac < 4; ac++)
                for (int db = 0; db < 2; db++)
                    for (int dd = 0; dd < 6; dd++) begin
                        m = db + 1;
                        use_r = 1'b1; async_r = md[0]; dbl = db[0];
                        wl = 2'd1; wa = 2'(ac); wt = 2'd1;
                        ready = 1'b0;
                        repeat (4) @(negedge clk);
                        run_access(1'b1, dd, 1'b0, l, w, t);
                        exp_w = (ac + 1) * m;
                        if (md == 0) begin
                            if (dd + 1 > exp_w) exp_w = dd + 1;
                            check(w == exp_w, "R7 sync ready width", w, exp_w);
                        end else begin
                            if (dd + 3 > exp_w) exp_w = dd + 3;
                            check(w == exp_w, "R8 async ready width", w, exp_w);
                        end
                        check(l == m && t == m, "R2 R4 phases with ready", l + t, 2 * m);
                    end

        // R9: configuration rewritten mid-access does not alter it
        ready = 1'b0; use_r = 1'b0; async_r = 1'b0; dbl = 1'b0;
        rl = 2'd2; ra = 2'd2; rt = 2'd1;
        run_access(1'b0, -1, 1'b1, l, w, t);
        check(l == 2, "R9 lead snapshot", l, 2);
        check(w == 3, "R9 active snapshot", w, 3);
        check(t == 1, "R9 trail snapshot", t, 1);

        // R10: exhaustive illegal-flag table
        for (int u = 0; u < 2; u++)
            for (int a = 0; a < 2; a++)
                for (int db = 0; db < 2; db++)
                    for (int code = 0; code < 256; code++) begin
                        @(negedge clk);
                        use_r = u[0]; async_r = a[0]; dbl = db[0];
                        rl = code[1:0]; ra = code[3:2]; wl = code[5:4]; wa = code[7:6];
                        @(negedge clk);
                        check(illegal == (exp_bad(code & 3, (code >> 2) & 3, u[0], a[0]) ||
                                          exp_bad((code >> 4) & 3, (code >> 6) & 3, u[0], a[0])),
                              "R10 illegal flag", int'(illegal), code);
                    end

        // R10: a flagged configuration still runs
        use_r = 1'b0; rl = 2'd0; ra = 2'd0; rt = 2'd0; dbl = 1'b0;
        @(negedge clk);
        run_access(1'b0, -1, 1'b0, l, w, t);
        check(illegal == 1'b1, "R10 flag on zero lead", int'(illegal), 1);
        check(l == 0 && w == 1 && t == 0, "R10 illegal access runs", w, 1);

        finish_run();
    end
endmodule